// File: doc/BRIEF.md
# Frame-Synchronous Deinterlacer Control Bank

This block is the run-time settings bank that sits between a host processor and a streaming video deinterlacer. A host reaches it through a small word-addressed slave port with read, write, address, write data, read data and wait signals. Through this port the host can start and stop the core, see whether a frame is in flight, force a user motion value, and set a 16-bit blend weight. The blend weight runs from 0, which weaves the fields, to 65535, which bobs them.

Host writes only reach staging registers. The processing core asks to begin each output frame with a request pulse. The bank grants that request only when the run bit is set and no frame is in flight. On the granting edge, the staged override flag and blend weight are copied into shadow registers, and these shadow registers drive the datapath for the whole frame. Because of this, the host can rewrite settings at any time without disturbing the frame in progress. The core reports the end of a frame with a done pulse.

Top module: `deint_ctl_bank`

## Requirements
- R1: After reset the run bit, the override flag, the blend weight, both shadow outputs and the status bit are all 0, and `frm_grant` is low.
- R2: Word 0 holds the run bit in bit 0. A write stores `host_wdata[0]`. A read returns the run bit in bit 0 and zero in every other bit.
- R3: While the run bit is 0, `frm_req` is never granted and the shadow outputs keep their values.
- R4: When `frm_req` is high, the run bit is 1 and no frame is in flight, `frm_grant` is high in that same cycle. On that clock edge the shadow outputs take the staged override flag and blend weight.
- R5: Word 1 reads 1 in bit 0 from the edge after a grant until the edge that samples `frm_done`, and 0 otherwise. All other bits read 0, and writes to word 1 have no effect.
- R6: Word 2 stores `host_wdata[0]` as the override flag, which `shd_override` carries after the next grant. Reads of word 2 return zero.
- R7: Word 3 stores `host_wdata[15:0]` as the blend weight, which `shd_coef` carries after the next grant. The upper write bits are ignored, and reads of word 3 return zero.
- R8: Writes made while a frame is in flight leave the shadow outputs unchanged. They take effect at the following grant.
- R9: A write never asserts `host_wait`. A read holds `host_wait` high for its first cycle and low in the second cycle, and in that second cycle `host_rdata` is valid.
- R10: While a frame is in flight, a new `frm_req` is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read request, held until wait drops |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid when wait is low during a read |
| host_wait | output | 1 | Wait request |
| frm_req | input | 1 | Core asks to start a frame |
| frm_grant | output | 1 | Frame start accepted; shadows load on this edge |
| frm_done | input | 1 | Core finished the current frame |
| shd_override | output | 1 | Frame-stable motion override enable |
| shd_coef | output | 16 | Frame-stable blend weight |

## Verification
The blend weight is swept over every single-bit value and over the endpoints 0 and 65535. Junk is written into the upper data bits each time, so that lost bits, swapped bits and masking errors each show up as a distinct wrong shadow value. The override flag alternates between frames, which shows whether the flag is carried separately from the weight. In every frame, fresh values are written mid-frame. This separates a bank that copies at the grant from one that passes writes straight through, and a final frame with no new writes confirms the staged values are picked up. Requests are also made with the run bit cleared and while a frame is busy, to show that a grant is withheld in both cases.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int COEF_W = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_RUN  = 2'd0,
        REG_STAT = 2'd1,
        REG_OVR  = 2'd2,
        REG_COEF = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              pend;
        logic [DATA_W-1:0] rdata;
    } hif_st_t;

    typedef struct packed {
        logic              go;
        logic              ovr;
        logic [COEF_W-1:0] coef;
    } stage_st_t;

    typedef struct packed {
        logic              busy;
        logic              ovr;
        logic [COEF_W-1:0] coef;
    } seq_st_t;
endpackage

// File: rtl/dcb_host_if.sv
module dcb_host_if
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              go,
    input  logic              busy,
    output logic              wr_run,
    output logic              wr_ovr,
    output logic              wr_coef,
    output logic [DATA_W-1:0] rdata,
    output logic              waitreq
);
    hif_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wr_run  = 1'b0;
        wr_ovr  = 1'b0;
        wr_coef = 1'b0;
        if (wr) begin
            case (reg_addr_e'(addr))
                REG_RUN:  wr_run  = 1'b1;
                REG_OVR:  wr_ovr  = 1'b1;
                REG_COEF: wr_coef = 1'b1;
                default:  ;
            endcase
        end
        if (st_q.pend) begin
            st_d.pend = 1'b0;
        end else if (rd) begin
            st_d.pend  = 1'b1;
            st_d.rdata = '0;
            case (reg_addr_e'(addr))
                REG_RUN:  st_d.rdata[0] = go;
                REG_STAT: st_d.rdata[0] = busy;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata   = st_q.rdata;
    assign waitreq = rd & ~st_q.pend;
endmodule

// File: rtl/dcb_stage.sv
module dcb_stage
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_run,
    input  logic              wr_ovr,
    input  logic              wr_coef,
    input  logic [DATA_W-1:0] wdata,
    output logic              go,
    output logic              ovr,
    output logic [COEF_W-1:0] coef
);
    stage_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_run)  st_d.go   = wdata[0];
        if (wr_ovr)  st_d.ovr  = wdata[0];
        if (wr_coef) st_d.coef = wdata[COEF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign go   = st_q.go;
    assign ovr  = st_q.ovr;
    assign coef = st_q.coef;
endmodule

// File: rtl/dcb_frame_seq.sv
module dcb_frame_seq
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              done,
    input  logic              go,
    input  logic              stg_ovr,
    input  logic [COEF_W-1:0] stg_coef,
    output logic              grant,
    output logic              busy,
    output logic              shd_ovr,
    output logic [COEF_W-1:0] shd_coef
);
    seq_st_t st_d, st_q;
    logic    grant_c;

    always_comb begin
        st_d    = st_q;
        grant_c = req & go & ~st_q.busy;
        if (grant_c) begin
            st_d.busy = 1'b1;
            st_d.ovr  = stg_ovr;
            st_d.coef = stg_coef;
        end else if (st_q.busy && done) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant    = grant_c;
    assign busy     = st_q.busy;
    assign shd_ovr  = st_q.ovr;
    assign shd_coef = st_q.coef;
endmodule

// File: rtl/deint_ctl_bank.sv
module deint_ctl_bank
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_wait,
    input  logic              frm_req,
    output logic              frm_grant,
    input  logic              frm_done,
    output logic              shd_override,
    output logic [COEF_W-1:0] shd_coef
);
    logic              wr_run, wr_ovr, wr_coef;
    logic              stg_go, stg_ovr;
    logic [COEF_W-1:0] stg_coef;
    logic              busy;

    dcb_host_if u_hif (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (host_rd),
        .wr      (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .go      (stg_go),
        .busy    (busy),
        .wr_run  (wr_run),
        .wr_ovr  (wr_ovr),
        .wr_coef (wr_coef),
        .rdata   (host_rdata),
        .waitreq (host_wait)
    );

    dcb_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_run  (wr_run),
        .wr_ovr  (wr_ovr),
        .wr_coef (wr_coef),
        .wdata   (host_wdata),
        .go      (stg_go),
        .ovr     (stg_ovr),
        .coef    (stg_coef)
    );

    dcb_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (frm_req),
        .done     (frm_done),
        .go       (stg_go),
        .stg_ovr  (stg_ovr),
        .stg_coef (stg_coef),
        .grant    (frm_grant),
        .busy     (busy),
        .shd_ovr  (shd_override),
        .shd_coef (shd_coef)
    );
endmodule

// File: rtl/dcb_chk.sv
module dcb_chk
    import dcb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_wait,
    input logic              frm_grant,
    input logic              shd_override,
    input logic [COEF_W-1:0] shd_coef,
    input logic              stg_go,
    input logic              stg_ovr,
    input logic [COEF_W-1:0] stg_coef,
    input logic              busy
);
    assert_grant_needs_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_grant |-> stg_go);

    assert_shadow_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_grant |=> (shd_coef == $past(stg_coef)) && (shd_override == $past(stg_ovr)));

    assert_busy_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_grant |=> busy);

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_grant |=> $stable(shd_coef) && $stable(shd_override));

    assert_no_regrant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !frm_grant);

    assert_write_nowait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd) |-> !host_wait);

    assert_wo_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wait && host_addr[1]) |-> (host_rdata == '0));
endmodule

bind deint_ctl_bank dcb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rd      (host_rd),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_rdata   (host_rdata),
    .host_wait    (host_wait),
    .frm_grant    (frm_grant),
    .shd_override (shd_override),
    .shd_coef     (shd_coef),
    .stg_go       (stg_go),
    .stg_ovr      (stg_ovr),
    .stg_coef     (stg_coef),
    .busy         (busy)
);

// File: tb/tb_deint_ctl_bank.sv
`timescale 1ns/1ps
module tb_deint_ctl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_wait;
    logic        frm_req = 1'b0, frm_done = 1'b0;
    logic        frm_grant, shd_override;
    logic [15:0] shd_coef;

    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    deint_ctl_bank dut (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_wait(host_wait), .frm_req(frm_req), .frm_grant(frm_grant),
        .frm_done(frm_done), .shd_override(shd_override), .shd_coef(shd_coef)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        #1 chk(host_wait == 1'b0, "R9 write wait", {31'b0, host_wait}, 0);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 chk(host_wait == 1'b1, "R9 read wait first", {31'b0, host_wait}, 1);
        @(negedge clk);
        chk(host_wait == 1'b0, "R9 read wait second", {31'b0, host_wait}, 0);
        d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic req(output logic g);
        @(negedge clk);
        frm_req = 1'b1;
        #1 g = frm_grant;
        @(negedge clk);
        frm_req = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        frm_done = 1'b1;
        @(negedge clk);
        frm_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        g;
        logic [15:0] m_coef, mid_coef;
        logic        m_ovr, mid_ovr;

        repeat (3) @(negedge clk);
        chk(frm_grant == 0 && shd_coef == 0 && shd_override == 0, "R1 reset outputs", {15'b0, shd_coef, shd_override}, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            chk(r == 0, "R1 reset readback", r, 0);
        end

        // R3: run bit clear withholds grant
        wr(2'd3, 32'h0000_1234);
        wr(2'd2, 32'h1);
        for (int k = 0; k < 3; k++) begin
            req(g);
            chk(g == 0, "R3 no grant while stopped", {31'b0, g}, 0);
        end
        chk(shd_coef == 0 && shd_override == 0, "R3 shadow untouched", {15'b0, shd_coef, shd_override}, 0);

        // R2: run bit masking
        wr(2'd0, 32'hFFFF_FFFE); rd(2'd0, r); chk(r == 0, "R2 run bit clear", r, 0);
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, r); chk(r == 1, "R2 run bit set", r, 1);

        // R5: writes to status ignored
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, r); chk(r == 0, "R5 status write ignored", r, 0);

        // main sweep
        for (int i = 0; i < 18; i++) begin
            m_coef = (i < 16) ? 16'(1 << i) : ((i == 16) ? 16'h0000 : 16'hFFFF);
            m_ovr  = i[0];
            wr(2'd3, {16'(i * 16'h9E37 + 16'h5A5A), m_coef});
            wr(2'd2, {31'(i * 32'h0101_0101 + 32'h8000_0000) , m_ovr});
            rd(2'd2, r); chk(r == 0, "R6 override reads zero", r, 0);
            rd(2'd3, r); chk(r == 0, "R7 coefficient reads zero", r, 0);
            req(g);
            chk(g == 1, "R4 grant", {31'b0, g}, 1);
            chk(shd_coef == m_coef, "R7 shadow coefficient", {16'b0, shd_coef}, {16'b0, m_coef});
            chk(shd_override == m_ovr, "R6 shadow override", {31'b0, shd_override}, {31'b0, m_ovr});
            rd(2'd1, r); chk(r == 1, "R5 status busy", r, 1);
            mid_coef = ~m_coef ^ 16'(i);
            mid_ovr  = ~m_ovr;
            wr(2'd3, {16'hFFFF, mid_coef});
            wr(2'd2, {31'b0, mid_ovr});
            chk(shd_coef == m_coef && shd_override == m_ovr, "R8 shadow stable mid-frame",
                {15'b0, shd_coef, shd_override}, {15'b0, m_coef, m_ovr});
            req(g);
            chk(g == 0, "R10 no grant while busy", {31'b0, g}, 0);
            done_pulse();
            rd(2'd1, r); chk(r == 0, "R5 status idle", r, 0);
            if (i == 17) begin
                req(g);
                chk(g == 1 && shd_coef == mid_coef && shd_override == mid_ovr, "R8 staged values used next frame",
                    {15'b0, shd_coef, shd_override}, {15'b0, mid_coef, mid_ovr});
                done_pulse();
            end
        end

        // R3: clearing run mid-frame blocks the next frame
        wr(2'd3, 32'h0000_0ABC);
        req(g);
        chk(g == 1, "R4 grant before stop", {31'b0, g}, 1);
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h0000_0DEF);
        done_pulse();
        req(g);
        chk(g == 0, "R3 no grant after stop", {31'b0, g}, 0);
        chk(shd_coef == 16'h0ABC, "R3 shadow kept after stop", {16'b0, shd_coef}, 32'h0ABC);
        rd(2'd1, r); chk(r == 0, "R5 status stopped", r, 0);
        rd(2'd0, r); chk(r == 0, "R2 run readback cleared", r, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule